// File: doc/BRIEF.md
# Display RAM Command and Address Controller

This block sits between a bus adapter and a display scan engine. It accepts decoded byte transfers: instruction bytes, data writes, data reads and status reads. It keeps a byte-wide display memory of four pages by eighty columns, which is 2560 bits in total. It also holds the address state used to reach that memory: a page register and a column counter that steps forward after data accesses. In addition it holds the mode flags that the scan engine needs: display start line, column direction, duty, static all-lit drive and display enable.

Data reads are pipelined through an output latch. Each read returns the byte that the previous read fetched, and then fetches the byte at the current address. After any change of address, the first read is therefore a dummy read.

A read-modify-write mode stops the column counter from advancing on reads. When the End command is issued, the counter goes back to the column it held when the mode was entered. This lets a cursor cell be read, changed and rewritten in place.

Top module: `dram_cmd_ctrl`

## Requirements
- R1: After reset, the block is in this state:
  - the display is off, column direction is normal and duty is 1/16;
  - static drive is off, the start line is 0 and read-modify-write mode is off;
  - page and column are 0, and the read latch and `rd_data` are 0x00.
- R2: The addressing commands are:
  - byte 0xB8|p (p = 0..3) sets the page;
  - byte 0xC0|n (n = 0..31) sets the start line;
  - a byte from 0x00 to 0x4F sets the column;
  - column bytes 0x50 to 0x7F are ignored.
- R3: A data write stores its byte at the current page and column. The column then advances by one, and wraps from 79 to 0.
- R4: A data read drives `rd_data` with the byte fetched by the previous read. It then fetches the byte at the current address into the latch. Outside read-modify-write mode, a read advances the column like a write does.
- R5: Byte 0xE0 enters read-modify-write mode. In this mode reads leave the column unchanged and writes still advance it. Byte 0xEE leaves the mode and restores the column held at entry.
- R6: Byte 0xE2 clears the start line, the page and the column. It leaves the RAM and the mode flags unchanged.
- R7: The mode flag commands each have a 0 form and a 1 form:
  - 0xAE/0xAF turn the display off/on;
  - 0xA0/0xA1 select normal/reversed column direction;
  - 0xA4/0xA5 turn static drive off/on;
  - 0xA8/0xA9 select 1/16 or 1/32 duty.
- R8: A status read drives `rd_data` with a status byte:
  - bit 7 is busy, which always reads 0;
  - bit 6 is the column direction flag, 1 when reversed;
  - bit 5 is 1 while the display is off;
  - bit 4 is the reset flag, which always reads 0;
  - bits 3 to 0 read 0.
- R9: The scan port returns the RAM byte at `scan_page`/`scan_col` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_stb | input | 1 | Instruction byte strobe |
| wr_stb | input | 1 | Display data write strobe |
| rd_stb | input | 1 | Display data read strobe |
| st_stb | input | 1 | Status read strobe |
| wr_data | input | 8 | Instruction or data byte |
| rd_data | output | 8 | Read or status result, registered |
| scan_page | input | 2 | Scan port page |
| scan_col | input | 7 | Scan port column |
| scan_data | output | 8 | Scan port RAM byte |
| start_line | output | 5 | Display start line |
| col_rev | output | 1 | Reversed column direction |
| duty_32 | output | 1 | 1/32 duty selected |
| static_on | output | 1 | Static all-lit drive |
| disp_on | output | 1 | Display enabled |
| rmw_on | output | 1 | Read-modify-write mode active |

## Verification
The main function is exercised in several ways:
- Sequential writes followed by reads from a re-set address show whether the read pipeline yields the dummy byte and then the stored bytes in order.
- A write run across column 79 separates correct wrapping from overflow.
- A rejected column byte (0x50) followed by a write shows whether out-of-range addresses are ignored.
- An interleaved read/write sequence in read-modify-write mode tells apart these cases: reads holding the column, writes advancing it, and End restoring the entry column.
- Status reads after each flag command show which bit each flag lands on.

// File: rtl/dram_cmd_ctrl.sv
module dram_cmd_ctrl #(
  parameter int PAGES = 4,
  parameter int COLS  = 80,
  parameter int LINES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_stb,
  input  logic       wr_stb,
  input  logic       rd_stb,
  input  logic       st_stb,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic [1:0] scan_page,
  input  logic [6:0] scan_col,
  output logic [7:0] scan_data,
  output logic [4:0] start_line,
  output logic       col_rev,
  output logic       duty_32,
  output logic       static_on,
  output logic       disp_on,
  output logic       rmw_on
);
  localparam int DEPTH = PAGES * COLS;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(COLS);
  localparam int PW    = $clog2(PAGES);
  localparam int LW    = $clog2(LINES);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] page_q;
  logic [CW-1:0] col_q, col_saved, col_inc;
  logic [7:0]    latch_q;
  logic [AW-1:0] acc_addr, scan_addr;

  wire wr_go = wr_stb & ~cmd_stb;
  wire rd_go = rd_stb & ~cmd_stb & ~wr_stb;
  wire st_go = st_stb & ~cmd_stb & ~wr_stb & ~rd_stb;

  wire is_col  = cmd_stb && (wr_data < 8'(COLS));
  wire is_page = cmd_stb && (wr_data[7:2] == 6'b101110);
  wire is_line = cmd_stb && (wr_data[7:5] == 3'b110);
  wire is_rst  = cmd_stb && (wr_data == 8'hE2);
  wire is_rmw  = cmd_stb && (wr_data == 8'hE0);
  wire is_end  = cmd_stb && (wr_data == 8'hEE);

  assign col_inc   = (col_q == CW'(COLS - 1)) ? '0 : col_q + 1'b1;
  assign acc_addr  = AW'(page_q) * AW'(COLS) + AW'(col_q);
  assign scan_addr = AW'(scan_page[PW-1:0]) * AW'(COLS) + AW'(scan_col[CW-1:0]);
  assign scan_data = mem[scan_addr];

  always_ff @(posedge clk)
    if (wr_go) mem[acc_addr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0; col_q <= '0; col_saved <= '0; latch_q <= '0; rd_data <= '0;
      start_line <= '0; col_rev <= 1'b0; duty_32 <= 1'b0; static_on <= 1'b0;
      disp_on <= 1'b0; rmw_on <= 1'b0;
    end else begin
      if (cmd_stb) begin
        case (wr_data)
          8'hAE, 8'hAF: disp_on   <= wr_data[0];
          8'hA0, 8'hA1: col_rev   <= wr_data[0];
          8'hA4, 8'hA5: static_on <= wr_data[0];
          8'hA8, 8'hA9: duty_32   <= wr_data[0];
          default: ;
        endcase
        if (is_page) page_q <= wr_data[PW-1:0];
        if (is_line) start_line <= wr_data[LW-1:0];
        if (is_col)  col_q <= wr_data[CW-1:0];
        if (is_rst) begin
          page_q <= '0; col_q <= '0; start_line <= '0;
        end
        if (is_rmw) begin
          rmw_on <= 1'b1; col_saved <= col_q;
        end
        if (is_end) begin
          rmw_on <= 1'b0;
          if (rmw_on) col_q <= col_saved;
        end
      end else if (wr_go) begin
        col_q <= col_inc;
      end else if (rd_go) begin
        rd_data <= latch_q;
        latch_q <= mem[acc_addr];
        if (!rmw_on) col_q <= col_inc;
      end else if (st_go) begin
        rd_data <= {1'b0, col_rev, ~disp_on, 1'b0, 4'b0000};
      end
    end
  end

  p_col_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    col_q < CW'(COLS));

  p_wr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go && col_q != CW'(COLS - 1) |=> col_q == $past(col_q) + 1'b1);

  p_rmw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go && rmw_on |=> $stable(col_q));

  p_rd_pipe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rd_data == $past(latch_q));

  p_reset_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_rst |=> col_q == '0 && page_q == '0 && start_line == '0);

  p_end_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_end && rmw_on |=> col_q == $past(col_saved) && !rmw_on);

  p_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_go |=> rd_data[7] == 1'b0 && rd_data[3:0] == 4'b0000);
endmodule

// File: tb/dram_cmd_ctrl_tb.sv
module dram_cmd_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_stb = 0, wr_stb = 0, rd_stb = 0, st_stb = 0;
  logic [7:0] wr_data = '0, rd_data, scan_data;
  logic [1:0] scan_page = '0;
  logic [6:0] scan_col = '0;
  logic [4:0] start_line;
  logic col_rev, duty_32, static_on, disp_on, rmw_on;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dram_cmd_ctrl dut_i (.clk, .rst_n, .cmd_stb, .wr_stb, .rd_stb, .st_stb,
    .wr_data, .rd_data, .scan_page, .scan_col, .scan_data, .start_line,
    .col_rev, .duty_32, .static_on, .disp_on, .rmw_on);

  localparam logic [2:0] CM = 3'd0, WR = 3'd1, RD = 3'd2, RN = 3'd3, ST = 3'd4;
  localparam int NV = 43;
  localparam logic [18:0] VEC [NV] = '{
    {ST, 8'h00, 8'h20},                       // R1/R8 display off after reset
    {CM, 8'hB9, 8'h00}, {CM, 8'h05, 8'h00},   // R2 page 1, column 5
    {WR, 8'h11, 8'h00}, {WR, 8'h22, 8'h00},
    {CM, 8'h05, 8'h00}, {RN, 8'h00, 8'h00},   // R4 dummy read
    {RD, 8'h00, 8'h11}, {RD, 8'h00, 8'h22},   // R4 R3 sequential
    {CM, 8'h4F, 8'h00}, {WR, 8'h33, 8'h00}, {WR, 8'h44, 8'h00},
    {CM, 8'h4F, 8'h00}, {RN, 8'h00, 8'h00},
    {RD, 8'h00, 8'h33}, {RD, 8'h00, 8'h44},   // R3 wrap 79 -> 0
    {CM, 8'h4F, 8'h00}, {CM, 8'h50, 8'h00},   // R2 0x50 ignored
    {WR, 8'h55, 8'h00}, {CM, 8'h4F, 8'h00}, {RN, 8'h00, 8'h00},
    {RD, 8'h00, 8'h55},
    {CM, 8'h0A, 8'h00}, {WR, 8'h01, 8'h00}, {WR, 8'h02, 8'h00},
    {CM, 8'h0A, 8'h00}, {CM, 8'hE0, 8'h00}, {RN, 8'h00, 8'h00},
    {RD, 8'h00, 8'h01}, {WR, 8'h81, 8'h00},   // R5 read holds column
    {RD, 8'h00, 8'h01}, {RD, 8'h00, 8'h02},
    {CM, 8'hEE, 8'h00}, {RN, 8'h00, 8'h00},
    {RD, 8'h00, 8'h81},                       // R5 End restores column
    {CM, 8'hAF, 8'h00}, {ST, 8'h00, 8'h00},   // R7 R8
    {CM, 8'hA1, 8'h00}, {ST, 8'h00, 8'h40},
    {CM, 8'hAE, 8'h00}, {ST, 8'h00, 8'h60},
    {CM, 8'hA0, 8'h00}, {ST, 8'h00, 8'h20}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [2:0] k, input logic [7:0] b);
    @(negedge clk);
    wr_data = b;
    cmd_stb = (k == CM); wr_stb = (k == WR);
    rd_stb = (k == RD || k == RN); st_stb = (k == ST);
    @(negedge clk);
    cmd_stb = 0; wr_stb = 0; rd_stb = 0; st_stb = 0;
  endtask

  task automatic peek(input logic [1:0] p, input logic [6:0] c, output logic [7:0] v);
    scan_page = p; scan_col = c;
    #1 v = scan_data;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 flags", {2'b00, disp_on, col_rev, duty_32, static_on, rmw_on, 1'b0}, 8'h00);
    check("R1 start_line", {3'b0, start_line}, 8'h00);
    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][18:16], VEC[i][15:8]);
      if (VEC[i][18:16] == RD || VEC[i][18:16] == ST)
        check($sformatf("R4/R8 vector %0d", i), rd_data, VEC[i][7:0]);
    end
    peek(2'd1, 7'd5, v);  check("R9 scan p1 c5", v, 8'h11);
    peek(2'd1, 7'd0, v);  check("R9 scan p1 c0", v, 8'h44);
    peek(2'd1, 7'd10, v); check("R9 scan p1 c10", v, 8'h81);
    xfer(CM, 8'hC5); check("R2 start line", {3'b0, start_line}, 8'h05);
    xfer(CM, 8'hA9); check("R7 duty 1/32", {7'b0, duty_32}, 8'h01);
    xfer(CM, 8'hA5); check("R7 static on", {7'b0, static_on}, 8'h01);
    xfer(CM, 8'hA8); check("R7 duty 1/16", {7'b0, duty_32}, 8'h00);
    xfer(CM, 8'hA4); check("R7 static off", {7'b0, static_on}, 8'h00);
    xfer(CM, 8'hE0); check("R5 rmw on", {7'b0, rmw_on}, 8'h01);
    xfer(CM, 8'hEE); check("R5 rmw off", {7'b0, rmw_on}, 8'h00);
    xfer(CM, 8'hBA); xfer(CM, 8'h10); xfer(CM, 8'hE2);
    check("R6 start line cleared", {3'b0, start_line}, 8'h00);
    xfer(WR, 8'h77); xfer(WR, 8'h78);
    peek(2'd0, 7'd0, v); check("R6 write at p0 c0", v, 8'h77);
    peek(2'd0, 7'd1, v); check("R6 write at p0 c1", v, 8'h78);
    check("R6 flags kept", {7'b0, disp_on}, 8'h00);
    peek(2'd1, 7'd5, v); check("R6 RAM kept", v, 8'h11);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule